// File: doc/BRIEF.md
# Receive DMA Descriptor-Ring Engine

This block is the receive half of a DMA channel. It takes bytes from one of two peripheral byte streams and stores them into memory buffers. Each buffer is described by a three-word descriptor, and the descriptors form a circular ring at a fixed base address. The engine reads the descriptor at the current ring index and checks its ownership flag. If the flag is set, it forms a 20-bit buffer address and writes incoming bytes until the buffer's byte count is reached or the packet ends. It then returns the descriptor to software and steps to the next ring entry.

A packet longer than one buffer continues in the next owned descriptor. When the engine meets a descriptor that software has not handed over, it raises the buffer-unavailable interrupt. It then waits until software requests a re-poll. Three interrupt sources exist: end of packet, buffer unavailable and buffer full. The buffer-full interrupt is gated both per descriptor and per channel. A priority field is passed on, normalised, to an external arbiter that sits outside this block.

Top module: `rx_desc_ring_dma`

## Requirements
- R1: Descriptor i sits at byte address DESC_BASE + 6*i and its words are 16-bit little-endian.
  - Word at +0 is the low 16 buffer-address bits.
  - Word at +2 carries the address bits 19:16 in bits 3:0 and the ownership flag in bit 15. Bits 7:4 are ignored for addressing.
  - Word at +4 carries the byte count in bits 11:0 and a buffer-full interrupt enable in bit 15.
  - Byte n of a buffer goes to {w1[3:0], w0} + n as a byte write.
- R2: A descriptor is used only when its ownership bit is 1. While the engine is waiting on a descriptor that is not owned, it accepts no receive bytes.
- R3: Bytes are written in arrival order at consecutive addresses, up to the byte count. If the buffer fills before the packet's last byte, the rest of the packet continues at offset 0 of the next owned descriptor.
- R4: The ring index advances by one after each buffer closes and wraps from RING_N-1 to 0. A load of the index (0 selects the first entry) is accepted only while the engine is idle or waiting.
- R5: When a buffer closes, the engine rewrites word +2 of the descriptor as a 16-bit write with bit 15 cleared and all other bits kept. When ctl_keep_own is 1, no write to the descriptor is made.
- R6: irq_eop pulses for one cycle after a buffer closes on a packet's last byte, if ctl_eop_ie is 1.
- R7: irq_unav pulses for one cycle each time a fetched descriptor has ownership bit 0, if ctl_unav_ie is 1. The engine then issues no memory access until ctl_poll or a disable.
- R8: irq_tc pulses for one cycle when a buffer closes because its byte count was reached. It fires only if both the descriptor's bit 15 of word +4 and ctl_tc_ie are 1.
- R9: A ctl_poll pulse while waiting makes the engine read the current descriptor's ownership word again.
- R10: ctl_src_sel = 0 takes stream A and 1 takes stream B. The ready of the stream that is not selected stays 0.
- R11: chan_prio follows ctl_prio one cycle later with 00 low, 01 medium and 10 high. The unused code 11 is passed on as 00.
- R12: After reset, and while ctl_en is 0 with the engine idle or waiting, the engine makes no memory access, drives both readies low and holds all interrupts low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Channel enable |
| ctl_eop_ie | input | 1 | End-of-packet interrupt enable |
| ctl_unav_ie | input | 1 | Buffer-unavailable interrupt enable |
| ctl_tc_ie | input | 1 | Channel-level buffer-full interrupt enable |
| ctl_keep_own | input | 1 | Leave ownership bits set on buffer close |
| ctl_src_sel | input | 1 | Receive source select (0 = A, 1 = B) |
| ctl_prio | input | 2 | Channel priority code |
| ctl_poll | input | 1 | Re-poll ownership of the current descriptor |
| idx_load | input | 1 | Load the ring index |
| idx_val | input | IDX_W | Ring index value to load |
| a_valid | input | 1 | Stream A byte valid |
| a_data | input | 8 | Stream A byte |
| a_last | input | 1 | Stream A last byte of packet |
| a_ready | output | 1 | Stream A byte accepted |
| b_valid | input | 1 | Stream B byte valid |
| b_data | input | 8 | Stream B byte |
| b_last | input | 1 | Stream B last byte of packet |
| b_ready | output | 1 | Stream B byte accepted |
| mem_addr | output | AW | Memory byte address |
| mem_re | output | 1 | 16-bit read, data in the next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wide | output | 1 | Write is 16-bit (1) or a byte (0) |
| mem_wdata | output | 16 | Write data (byte in bits 7:0) |
| mem_rdata | input | 16 | Read data |
| irq_eop | output | 1 | End-of-packet interrupt pulse |
| irq_unav | output | 1 | Buffer-unavailable interrupt pulse |
| irq_tc | output | 1 | Buffer-full interrupt pulse |
| chan_prio | output | 2 | Normalised priority to the arbiter |

## Verification
The bench pushes a packet that spills from one buffer into the next, a packet that ends exactly on a buffer's count, and one that wraps the ring onto a returned descriptor.

- A design that mis-sequenced the offset or the index would scatter bytes away from the computed addresses.
- A design that tested only one enable would fire irq_tc on the non-full and the descriptor-disabled cases.
- After the wrap, the bench re-polls once with ownership still clear and once after setting it, which exposes an engine that skips the re-read or one that accepts bytes while waiting.
- The ignored upper address nibble, the keep-ownership write suppression and a direct index load each leave a distinct mark in memory that the bench compares.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RD1, ST_CK1, ST_RD0, ST_LD0,
    ST_RD2, ST_LD2, ST_XFER, ST_WB, ST_STALL
  } rdr_state_e;

  localparam int OWN_BIT    = 15;
  localparam int TCE_BIT    = 15;
  localparam int DESC_BYTES = 6;
endpackage

// File: rtl/rdr_ring_index.sv
module rdr_ring_index #(
  parameter int RING_N = 4,
  localparam int IDX_W = (RING_N > 1) ? $clog2(RING_N) : 1
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(RING_N - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (load) begin
      idx <= (load_val > LAST) ? '0 : load_val;
    end else if (adv) begin
      idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end
  end

  // R4
  idx_in_ring_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && idx == LAST) |=> idx == '0);
endmodule

// File: rtl/rdr_src_mux.sv
module rdr_src_mux (
  input  logic       sel,
  input  logic       take,
  input  logic       a_valid,
  input  logic [7:0] a_data,
  input  logic       a_last,
  input  logic       b_valid,
  input  logic [7:0] b_data,
  input  logic       b_last,
  output logic       a_ready,
  output logic       b_ready,
  output logic       s_valid,
  output logic [7:0] s_data,
  output logic       s_last
);
  always_comb begin
    a_ready = take & ~sel;
    b_ready = take & sel;
    s_valid = sel ? b_valid : a_valid;
    s_data  = sel ? b_data  : a_data;
    s_last  = sel ? b_last  : a_last;
  end
endmodule

// File: rtl/rdr_out_regs.sv
module rdr_out_regs (
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_eop,
  input  logic       ev_unav,
  input  logic       ev_tc,
  input  logic       en_eop,
  input  logic       en_unav,
  input  logic       en_tc,
  input  logic [1:0] prio_in,
  output logic       irq_eop,
  output logic       irq_unav,
  output logic       irq_tc,
  output logic [1:0] chan_prio
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_eop   <= 1'b0;
      irq_unav  <= 1'b0;
      irq_tc    <= 1'b0;
      chan_prio <= 2'b00;
    end else begin
      irq_eop   <= ev_eop & en_eop;
      irq_unav  <= ev_unav & en_unav;
      irq_tc    <= ev_tc & en_tc;
      chan_prio <= (prio_in == 2'b11) ? 2'b00 : prio_in;
    end
  end

  // R11
  prio_high_chk: assert property (@(posedge clk) disable iff (rst)
    (prio_in == 2'b10) |=> (chan_prio == 2'b10));
endmodule

// File: rtl/rx_desc_ring_dma.sv
module rx_desc_ring_dma
  import rdr_pkg::*;
#(
  parameter int AW = 20,
  parameter int CNT_W = 12,
  parameter int RING_N = 4,
  parameter logic [AW-1:0] DESC_BASE = 'h00100,
  localparam int IDX_W = (RING_N > 1) ? $clog2(RING_N) : 1
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_en,
  input  logic             ctl_eop_ie,
  input  logic             ctl_unav_ie,
  input  logic             ctl_tc_ie,
  input  logic             ctl_keep_own,
  input  logic             ctl_src_sel,
  input  logic [1:0]       ctl_prio,
  input  logic             ctl_poll,
  input  logic             idx_load,
  input  logic [IDX_W-1:0] idx_val,
  input  logic             a_valid,
  input  logic [7:0]       a_data,
  input  logic             a_last,
  output logic             a_ready,
  input  logic             b_valid,
  input  logic [7:0]       b_data,
  input  logic             b_last,
  output logic             b_ready,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_re,
  output logic             mem_we,
  output logic             mem_wide,
  output logic [15:0]      mem_wdata,
  input  logic [15:0]      mem_rdata,
  output logic             irq_eop,
  output logic             irq_unav,
  output logic             irq_tc,
  output logic [1:0]       chan_prio
);
  localparam int HI_W = AW - 16;

  rdr_state_e       state;
  logic [15:0]      w1_q, lo_q;
  logic [CNT_W-1:0] cnt_q, off_q, off_nx;
  logic             tce_q, eop_q, full_q;
  logic [IDX_W-1:0] idx;
  logic [AW-1:0]    desc_a, buf_a;
  logic             take, s_valid, s_last, adv, ld_ok;
  logic [7:0]       s_data;
  logic             ev_eop, ev_unav, ev_tc;
  logic             unused_w2;

  assign unused_w2 = ^mem_rdata[14:CNT_W];
  assign off_nx    = off_q + CNT_W'(1);
  assign desc_a    = DESC_BASE + AW'(idx) * AW'(DESC_BYTES);
  assign buf_a     = {w1_q[HI_W-1:0], lo_q} + AW'(off_q);
  assign ld_ok     = idx_load && (state == ST_IDLE || state == ST_STALL);

  rdr_ring_index #(.RING_N(RING_N)) u_idx (
    .clk(clk), .rst(rst), .load(ld_ok), .load_val(idx_val), .adv(adv), .idx(idx));

  rdr_src_mux u_mux (
    .sel(ctl_src_sel), .take(take),
    .a_valid(a_valid), .a_data(a_data), .a_last(a_last),
    .b_valid(b_valid), .b_data(b_data), .b_last(b_last),
    .a_ready(a_ready), .b_ready(b_ready),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last));

  rdr_out_regs u_out (
    .clk(clk), .rst(rst), .ev_eop(ev_eop), .ev_unav(ev_unav), .ev_tc(ev_tc),
    .en_eop(ctl_eop_ie), .en_unav(ctl_unav_ie), .en_tc(ctl_tc_ie),
    .prio_in(ctl_prio), .irq_eop(irq_eop), .irq_unav(irq_unav),
    .irq_tc(irq_tc), .chan_prio(chan_prio));

  always_comb begin
    mem_re = 1'b0; mem_we = 1'b0; mem_wide = 1'b0;
    mem_addr = desc_a; mem_wdata = '0; take = 1'b0; adv = 1'b0;
    ev_eop = 1'b0; ev_unav = 1'b0; ev_tc = 1'b0;
    case (state)
      ST_RD1: begin mem_re = 1'b1; mem_addr = desc_a + AW'(2); end
      ST_CK1: ev_unav = ~mem_rdata[OWN_BIT];
      ST_RD0: mem_re = 1'b1;
      ST_RD2: begin mem_re = 1'b1; mem_addr = desc_a + AW'(4); end
      ST_XFER: begin
        take = 1'b1;
        if (s_valid) begin
          mem_we = 1'b1; mem_addr = buf_a; mem_wdata = {8'h00, s_data};
        end
      end
      ST_WB: begin
        adv = 1'b1; ev_eop = eop_q; ev_tc = full_q & tce_q;
        if (!ctl_keep_own) begin
          mem_we = 1'b1; mem_wide = 1'b1; mem_addr = desc_a + AW'(2);
          mem_wdata = {1'b0, w1_q[14:0]};
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; w1_q <= '0; lo_q <= '0; cnt_q <= '0; off_q <= '0;
      tce_q <= 1'b0; eop_q <= 1'b0; full_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (ctl_en) state <= ST_RD1;
        ST_RD1:  state <= ST_CK1;
        ST_CK1: begin
          if (mem_rdata[OWN_BIT]) begin w1_q <= mem_rdata; state <= ST_RD0; end
          else state <= ST_STALL;
        end
        ST_RD0:  state <= ST_LD0;
        ST_LD0:  begin lo_q <= mem_rdata; state <= ST_RD2; end
        ST_RD2:  state <= ST_LD2;
        ST_LD2: begin
          cnt_q <= mem_rdata[CNT_W-1:0]; tce_q <= mem_rdata[TCE_BIT];
          off_q <= '0; state <= ST_XFER;
        end
        ST_XFER: if (s_valid) begin
          off_q <= off_nx;
          if (s_last || off_nx == cnt_q) begin
            eop_q <= s_last; full_q <= (off_nx == cnt_q); state <= ST_WB;
          end
        end
        ST_WB:    state <= ctl_en ? ST_RD1 : ST_IDLE;
        ST_STALL: if (!ctl_en) state <= ST_IDLE; else if (ctl_poll) state <= ST_RD1;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R2
  owned_write_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !mem_wide) |-> w1_q[OWN_BIT]);
  // R3
  within_count_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !mem_wide) |-> (off_q < cnt_q || cnt_q == '0));
  // R5
  own_release_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_wide) |-> (!mem_wdata[OWN_BIT] && !ctl_keep_own));
  // R7
  stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STALL && !ctl_poll) |=> (!mem_re && !mem_we));
  // R8
  tc_on_close_chk: assert property (@(posedge clk) disable iff (rst)
    irq_tc |-> ($past(state) == ST_WB && $past(full_q && tce_q)));
  // R6
  eop_on_close_chk: assert property (@(posedge clk) disable iff (rst)
    irq_eop |-> ($past(state) == ST_WB));
  // R10
  one_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({a_ready, b_ready}));
endmodule

// File: tb/rx_desc_ring_dma_test.sv
module rx_desc_ring_dma_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int RING_N = 4;
  localparam int BASE = 'h100;

  logic clk = 0, rst = 1;
  logic ctl_en = 0, ctl_eop_ie = 0, ctl_unav_ie = 0, ctl_tc_ie = 0, ctl_keep_own = 0;
  logic ctl_src_sel = 0, ctl_poll = 0, idx_load = 0;
  logic [1:0] ctl_prio = 0, idx_val = 0;
  logic a_valid = 0, a_last = 0, b_valid = 0, b_last = 0;
  logic [7:0] a_data = 0, b_data = 0;
  logic a_ready, b_ready, mem_re, mem_we, mem_wide;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic irq_eop, irq_unav, irq_tc;
  logic [1:0] chan_prio;

  bit [7:0] m [int unsigned];
  int n_chk = 0, n_bad = 0, n_eop = 0, n_unav = 0, n_tc = 0, n_acc = 0;
  bit p3_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_desc_ring_dma #(.AW(AW), .RING_N(RING_N)) uut (.*);

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= {m[mem_addr + 1], m[mem_addr]};
    if (mem_we) begin
      m[mem_addr] = mem_wdata[7:0];
      if (mem_wide) m[mem_addr + 1] = mem_wdata[15:8];
    end
    if (!rst) begin
      if (irq_eop) n_eop++;
      if (irq_unav) n_unav++;
      if (irq_tc) n_tc++;
      if (mem_re || mem_we) n_acc++;
    end
  end

  function automatic bit [7:0] pat(int k);
    return 8'(k * 37 + 5);
  endfunction

  function automatic int rd16(int a);
    return {m[a + 1], m[a]};
  endfunction

  task automatic wr16(int a, int v);
    m[a] = v[7:0];
    m[a + 1] = v[15:8];
  endtask

  task automatic set_desc(int i, int buf_a, int cnt, bit tce, bit own, int junk);
    int d = BASE + 6 * i;
    wr16(d, buf_a & 'hFFFF);
    wr16(d + 2, (int'(own) << 15) | ((junk & 'hF) << 4) | ((buf_a >> 16) & 'hF));
    wr16(d + 4, (int'(tce) << 15) | (cnt & 'hFFF));
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(bit src, bit [7:0] d, bit last);
    if (!src) begin a_valid = 1; a_data = d; a_last = last; end
    else begin b_valid = 1; b_data = d; b_last = last; end
    while (!(src ? b_ready : a_ready)) @(negedge clk);
    @(negedge clk);
    a_valid = 0; b_valid = 0; a_last = 0; b_last = 0;
  endtask

  task automatic pulse_poll();
    ctl_poll = 1; cyc(1); ctl_poll = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    set_desc(0, 'h12000, 4, 1, 1, 'hF);
    set_desc(1, 'h03000, 4, 1, 1, 0);
    set_desc(2, 'h04000, 8, 1, 1, 0);
    set_desc(3, 'h05000, 3, 0, 1, 0);
    cyc(3); rst = 0; cyc(1);
    // R12 reset state
    check("R12 a_ready", a_ready, 0);
    check("R12 b_ready", b_ready, 0);
    check("R12 irqs", {irq_eop, irq_unav, irq_tc}, 0);
    check("R11 prio reset", chan_prio, 0);
    cyc(10);
    check("R12 no access disabled", n_acc, 0);

    ctl_eop_ie = 1; ctl_unav_ie = 1; ctl_tc_ie = 1; ctl_en = 1;
    // Packet 1: 6 bytes, spills from desc0 (4) into desc1
    for (int k = 0; k < 6; k++) send(0, pat(k), k == 5);
    cyc(20);
    for (int k = 0; k < 4; k++) check("R1 R3 buf0 byte", m['h12000 + k], pat(k));
    for (int k = 0; k < 2; k++) check("R3 spill buf1 byte", m['h3000 + k], pat(4 + k));
    check("R1 high nibble ignored", m['h2000], 0);
    check("R5 desc0 own cleared", rd16(BASE + 2), 'h00F1);
    check("R5 desc1 own cleared", rd16(BASE + 8), 'h0000);
    check("R8 tc once (desc1 not full)", n_tc, 1);
    check("R6 eop packet1", n_eop, 1);

    // Packet 2 via source B: exactly fills desc2 (8 bytes)
    ctl_src_sel = 1; cyc(1);
    check("R10 a_ready low when B selected", a_ready, 0);
    for (int k = 0; k < 8; k++) send(1, pat(10 + k), k == 7);
    cyc(20);
    for (int k = 0; k < 8; k++) check("R10 buf2 byte", m['h4000 + k], pat(10 + k));
    check("R8 tc on exact fill", n_tc, 2);
    check("R6 eop packet2", n_eop, 2);

    // Packet 3 via A: 3 bytes in desc3, then wrap to desc0 (not owned)
    ctl_src_sel = 0;
    fork
      begin
        for (int k = 0; k < 5; k++) send(0, pat(20 + k), k == 4);
        p3_done = 1;
      end
    join_none
    cyc(40);
    for (int k = 0; k < 3; k++) check("R3 buf3 byte", m['h5000 + k], pat(20 + k));
    check("R7 unav on wrap", n_unav, 1);
    check("R2 no accept while stalled", a_ready, 0);
    check("R8 tc gated by descriptor", n_tc, 2);
    n_acc = 0; cyc(10);
    check("R7 no access while waiting", n_acc, 0);
    pulse_poll(); cyc(10);
    check("R9 poll re-reads, still not owned", n_unav, 2);
    set_desc(0, 'h06000, 4, 0, 1, 0);
    pulse_poll();
    wait (p3_done); cyc(20);
    for (int k = 0; k < 2; k++) check("R4 wrap buf0 new byte", m['h6000 + k], pat(23 + k));
    check("R6 eop packet3", n_eop, 3);
    check("R7 unav at desc1", n_unav, 3);

    // keep-ownership: desc1 refilled, 2 bytes fill it exactly
    set_desc(1, 'h07000, 2, 1, 1, 0);
    ctl_keep_own = 1; pulse_poll();
    send(0, pat(30), 0); send(0, pat(31), 1);
    cyc(20);
    check("R5 keep own word", rd16(BASE + 8), 'h8000);
    check("R3 buf1 refill byte", m['h7001], pat(31));
    check("R8 tc both enables", n_tc, 3);
    check("R7 unav at desc2", n_unav, 4);

    // Index load while waiting: jump to desc3
    ctl_keep_own = 0;
    set_desc(3, 'h08000, 3, 0, 1, 0);
    idx_val = 2'd3; idx_load = 1; cyc(1); idx_load = 0;
    pulse_poll();
    send(0, pat(40), 1);
    cyc(20);
    check("R4 index load used desc3", m['h8000], pat(40));
    check("R4 desc3 returned", rd16(BASE + 20), 'h0000);
    check("R6 eop after load", n_eop, 5);
    check("R4 wrap to desc0 unav", n_unav, 5);

    // Priority
    ctl_prio = 2'b10; cyc(2); check("R11 high", chan_prio, 2);
    ctl_prio = 2'b01; cyc(2); check("R11 medium", chan_prio, 1);
    ctl_prio = 2'b11; cyc(2); check("R11 code 11 to low", chan_prio, 0);

    // Disable while waiting
    ctl_en = 0; cyc(2); n_acc = 0; pulse_poll(); cyc(20);
    check("R12 disabled no access", n_acc, 0);

    summary();
    $finish;
  end
endmodule